// File: doc/BRIEF.md
# Configuration Port Reboot Sequencer

This block asks the device to reload its configuration from a chosen location in flash. It drives an 8-bit internal configuration access port. One start pulse makes it send a fixed script of 16-bit configuration commands, one byte per accepted write. The script contains a 24-bit flash start address and a flash read opcode. The opcode depends on the flash part fitted, and a typical value is 03. The address and the opcode are sampled on the start pulse. Changes to them after that pulse do not affect a script that is already being sent.

Each command word is sent as two bytes, high byte first. The port expects each byte with its bit order reversed end for end, and the block reverses every byte before it drives it. The port supplies an enable. A byte counts as accepted only on a cycle where the write strobe and the enable are both high, so the port can hold the block back for any number of cycles.

Top module: `cfg_reboot_seq`

## Requirements
- R1: During and after reset, and before any start pulse, `wrStrobe`, `busy` and `done` are low.
- R2: A start pulse sampled while idle makes `busy` and `wrStrobe` go high on the next cycle, with the first script byte on `wrByte`.
- R3: The script is 20 bytes long. Before reversal its bytes are: FF, FF, AA, 99, 32, 61, addr[15:8], addr[7:0], 32, 81, opcode, addr[23:16], 30, A1, 00, 0E, 20, 00, 20, 00.
- R4: Every script byte is bit-reversed before it is driven: `wrByte[i]` equals bit 7-i of the script byte.
- R5: The address and opcode are captured at the start pulse. Input changes while `busy` is high do not alter the bytes being sent.
- R6: The script advances one byte only on a cycle where `wrStrobe` and `portEn` are both high. Otherwise the same byte stays on `wrByte`.
- R7: After the 20th byte is accepted, `busy` and `wrStrobe` drop on the next cycle and `done` is high for exactly that one cycle.
- R8: A start pulse that arrives while `busy` is high is ignored. The script in progress neither restarts nor changes.
- R9: While idle, `wrByte` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to send the reboot script |
| flashAddr | input | 24 | Flash address to reload from |
| readOp | input | 8 | Flash read opcode |
| portEn | input | 1 | Port accepts the current byte this cycle |
| wrByte | output | 8 | Bit-reversed byte to the port |
| wrStrobe | output | 1 | Byte on `wrByte` is valid |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The in-RTL assertions check the following on every cycle:
- the byte index stays in range, and holds while the enable is low;
- `done` is a single pulse that follows acceptance of the final byte;
- the captured address and opcode stay stable through a run;
- a start pulse during a run does not disturb it;
- the output byte is zero while idle.

The byte values and their order, the bit reversal, and the exact cycle on which each output changes can only be shown by the bench's scenarios. The bench compares every cycle against a behavioural model under these conditions:
- an enable held high;
- an irregular enable pattern;
- address and opcode changes in the middle of a run;
- extra start pulses during a run;
- a new start on the same cycle as `done`.

// File: rtl/cfg_reboot_pkg.sv
package cfg_reboot_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 24;
  localparam int NUM_BYTES = 20;
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  typedef struct packed {
    logic load;
    logic advance;
    logic active;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfg_reboot_ctrl.sv
module cfg_reboot_ctrl
  import cfg_reboot_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             portEn,
  output ctrlStrobes_t     strb,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  always_comb begin
    strb.load    = (state == ST_IDLE) && start;
    strb.advance = (state == ST_RUN) && portEn;
    strb.active  = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          idx   <= '0;
        end
        ST_RUN: if (portEn) begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (idx <= LAST_IDX));

  assert_hold_no_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !portEn) |=> (state == ST_RUN && $stable(idx)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state == ST_RUN && portEn && idx == LAST_IDX));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && start && !portEn) |=> (state == ST_RUN && $stable(idx)));
endmodule

// File: rtl/cfg_reboot_dp.sv
module cfg_reboot_dp
  import cfg_reboot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] flashAddr,
  input  logic [BYTE_W-1:0] readOp,
  output logic [BYTE_W-1:0] wrByte
);
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] opQ;
  logic [BYTE_W-1:0] rawByte;
  logic [BYTE_W-1:0] revByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      opQ   <= '0;
    end else if (strb.load) begin
      addrQ <= flashAddr;
      opQ   <= readOp;
    end
  end

  always_comb begin
    case (idx)
      5'd0:    rawByte = 8'hFF;
      5'd1:    rawByte = 8'hFF;
      5'd2:    rawByte = 8'hAA;
      5'd3:    rawByte = 8'h99;
      5'd4:    rawByte = 8'h32;
      5'd5:    rawByte = 8'h61;
      5'd6:    rawByte = addrQ[15:8];
      5'd7:    rawByte = addrQ[7:0];
      5'd8:    rawByte = 8'h32;
      5'd9:    rawByte = 8'h81;
      5'd10:   rawByte = opQ;
      5'd11:   rawByte = addrQ[23:16];
      5'd12:   rawByte = 8'h30;
      5'd13:   rawByte = 8'hA1;
      5'd14:   rawByte = 8'h00;
      5'd15:   rawByte = 8'h0E;
      5'd16:   rawByte = 8'h20;
      5'd17:   rawByte = 8'h00;
      5'd18:   rawByte = 8'h20;
      5'd19:   rawByte = 8'h00;
      default: rawByte = 8'h00;
    endcase
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
    assign revByte[b] = rawByte[BYTE_W-1-b];
  end

  assign wrByte = strb.active ? revByte : '0;

  assert_capture_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.active && $past(strb.active)) |-> ($stable(addrQ) && $stable(opQ)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.active |-> (wrByte == '0));
endmodule

// File: rtl/cfg_reboot_seq.sv
module cfg_reboot_seq
  import cfg_reboot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] flashAddr,
  input  logic [BYTE_W-1:0] readOp,
  input  logic              portEn,
  output logic [BYTE_W-1:0] wrByte,
  output logic              wrStrobe,
  output logic              busy,
  output logic              done
);
  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] idx;

  cfg_reboot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .portEn(portEn),
    .strb(strb), .idx(idx), .done(done)
  );

  cfg_reboot_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .idx(idx),
    .flashAddr(flashAddr), .readOp(readOp), .wrByte(wrByte)
  );

  assign wrStrobe = strb.active;
  assign busy     = strb.active;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!wrStrobe && !busy && !done));

  assert_start_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

// File: tb/cfg_reboot_seq_bench.sv
`timescale 1ns/1ps
module cfg_reboot_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [23:0] flashAddr = '0;
  logic [7:0] readOp = '0;
  logic portEn = 1'b0;
  logic [7:0] wrByte;
  logic wrStrobe, busy, done;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  cfg_reboot_seq u_cfg_reboot_seq (
    .clk(clk), .rst(rst), .start(start), .flashAddr(flashAddr),
    .readOp(readOp), .portEn(portEn), .wrByte(wrByte),
    .wrStrobe(wrStrobe), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  byte unsigned q[$];
  bit mBusy = 0;
  bit mDone = 0;

  function automatic byte unsigned flip(byte unsigned x);
    byte unsigned r = 0;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  always @(posedge clk) begin
    mDone = 0;
    if (rst) begin
      mBusy = 0;
      q.delete();
    end else if (!mBusy && start) begin
      q = '{8'hFF, 8'hFF, 8'hAA, 8'h99, 8'h32, 8'h61,
            flashAddr[15:8], flashAddr[7:0], 8'h32, 8'h81,
            readOp, flashAddr[23:16], 8'h30, 8'hA1, 8'h00, 8'h0E,
            8'h20, 8'h00, 8'h20, 8'h00};
      mBusy = 1;
    end else if (mBusy && portEn) begin
      void'(q.pop_front());
      if (q.size() == 0) begin
        mBusy = 0;
        mDone = 1;
      end
    end
  end

  task automatic compare();
    byte unsigned eByte;
    eByte = mBusy ? flip(q[0]) : 8'h00;
    vectors++;
    if (busy !== mBusy || wrStrobe !== mBusy || done !== mDone || wrByte !== eByte) begin
      miscompares++;
      $display("FAIL %s t=%0t busy=%b/%b strobe=%b/%b done=%b/%b byte=%h/%h (actual/expected)",
               curReq, $time, busy, mBusy, wrStrobe, mBusy, done, mDone, wrByte, eByte);
    end
  endtask

  always @(negedge clk) compare();

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart(logic [23:0] a, logic [7:0] op);
    flashAddr = a; readOp = op; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) step();
    step();
  endtask

  initial begin
    int guard = 0;
    while (guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    curReq = "R1";
    step(4);
    rst = 1'b0;
    step(3);
    curReq = "R9";
    portEn = 1'b1;
    step(3);

    // R2 R3 R4: enable held high, typical opcode
    curReq = "R2_R3_R4";
    pulseStart(24'h123456, 8'h03);
    waitIdle();

    // R4: bit patterns with asymmetric bytes
    curReq = "R4";
    pulseStart(24'h01C380, 8'h0B);
    waitIdle();

    // R6: irregular enable
    curReq = "R6";
    pulseStart(24'hA5F00F, 8'h3B);
    for (int i = 0; i < 80 && busy; i++) begin
      portEn = ((i % 3) == 0) || ((i % 7) == 5);
      step();
    end
    portEn = 1'b1;
    waitIdle();

    // R5: inputs change mid-run
    curReq = "R5";
    portEn = 1'b0;
    pulseStart(24'h8E1D42, 8'h6B);
    for (int i = 0; i < 30; i++) begin
      flashAddr = 24'hFFFFFF - 24'(i * 4099);
      readOp = 8'(i * 37);
      portEn = i[0];
      step();
    end
    portEn = 1'b1;
    waitIdle();

    // R8: start pulses while busy
    curReq = "R8";
    pulseStart(24'h00FF00, 8'h03);
    for (int i = 0; i < 12; i++) begin
      start = i[1];
      flashAddr = 24'h777777;
      portEn = (i != 4);
      step();
    end
    start = 1'b0;
    portEn = 1'b1;
    waitIdle();

    // R7: done pulse, restart on the done cycle
    curReq = "R7";
    pulseStart(24'h345678, 8'h13);
    while (!(busy && wrByte == flip(8'h00) && q.size() == 1)) step();
    start = 1'b1; flashAddr = 24'hC0FFEE; readOp = 8'h03;
    step();           // last byte accepted at this edge
    step();           // done cycle: start sampled, new run begins
    start = 1'b0;
    waitIdle();

    // R1: reset mid-run
    curReq = "R1";
    pulseStart(24'h111111, 8'h03);
    step(5);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule